// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This unit carries out the three register-sourced accesses to control-and-status registers: a full write, a bit set and a bit clear. A request names the operation, a 12-bit register address, the source operand, a flag that tells whether the source register field of the instruction was nonzero, and the privilege level the hart runs at. The unit returns the register contents as they stood before the access, or flags an illegal-instruction fault when the access is not allowed.

All three operations are reduced to a single masked update, `next = (old & ~mask) | (value & mask)`. A write uses an all-ones mask with the source as the value. A set uses the source as mask and all ones as value. A clear uses the source as mask and zero as value. When the source register field is zero, a set or clear gets a zero mask and only reads. The unit contains three read/write example registers and one read-only identification register; the permission rules come from the address itself.

A request is presented for one cycle with `req_valid`; its response (`rsp_done`, `rsp_fault`, `rsp_old`) appears on the next cycle, and requests may follow each other on every cycle.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset `rsp_done` is low, and the three read/write registers (addresses 12'h340, 12'h140, 12'h041) read as zero.
- R2: Operation code 2'b01 (write) replaces the addressed register with `req_src` and returns the previous contents on `rsp_old`.
- R3: Operation code 2'b10 (set) with `req_src_nz` high makes the register `old | req_src` and returns the previous contents.
- R4: Operation code 2'b11 (clear) with `req_src_nz` high makes the register `old & ~req_src` and returns the previous contents.
- R5: A set or clear with `req_src_nz` low leaves the register unchanged whatever `req_src` holds, and returns its current contents.
- R6: An address that names none of the four implemented registers faults, leaves every register unchanged, and returns zero on `rsp_old`.
- R7: An access faults and changes nothing when `req_priv` is numerically below address bits [9:8] (0 user, 1 supervisor, 3 machine).
- R8: When address bits [11:10] are 2'b11 (read-only space) an access faults if its mask is nonzero: a write always faults, a set or clear faults only when `req_src_nz` is high and `req_src` is nonzero.
- R9: Every request taken with `req_valid` high produces `rsp_done` high on exactly the next cycle; `rsp_done` is low after a cycle without a request, and `rsp_fault` is only high together with `rsp_done`.
- R10: Operation code 2'b00 always faults and changes nothing.
- R11: The read-only register at 12'hF11 returns the parameter `ID_VALUE` on every legal read and never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 01 write, 10 set, 11 clear, 00 unused |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register field of the instruction is nonzero |
| req_priv | input | 2 | Current privilege level |
| rsp_done | output | 1 | Response for the previous cycle's request |
| rsp_fault | output | 1 | Illegal-instruction fault for that request |
| rsp_old | output | XLEN | Register contents before the access, zero on a fault |

## Verification
The read of the old value and the commit of the new one land on the same clock edge, so back-to-back requests to one register are the case where both functions meet: the second request must return exactly what the first one wrote. The bench provokes this by streaming write, set and clear to one address on consecutive cycles and, in the random phase, by issuing requests on most cycles over a small address pool. A bench model that applies the masked update in request order supplies each expected old value and fault flag, and the privilege and read-only faults are also driven in the same request to confirm a fault blocks the update.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned N_RW   = 3;

  localparam logic [ADDR_W-1:0] RW_ADDR [N_RW] = '{12'h340, 12'h140, 12'h041};
  localparam logic [ADDR_W-1:0] ID_ADDR        = 12'hF11;

  typedef struct packed {
    logic bad_op;
    logic unimpl;
    logic priv_low;
    logic ro_write;
  } fault_t;

endpackage

// File: rtl/csr_rmw_rstsync.sv
module csr_rmw_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/csr_rmw_opdec.sv
module csr_rmw_opdec
  import csr_rmw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic            src_nz,
  output logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] value,
  output logic            op_ok
);
  logic [XLEN-1:0] gated_src;

  always_comb begin
    gated_src = src_nz ? src : '0;
    mask  = '0;
    value = '0;
    op_ok = 1'b1;
    case (csr_op_e'(op))
      OP_WRITE: begin
        mask  = '1;
        value = src;
      end
      OP_SET: begin
        mask  = gated_src;
        value = '1;
      end
      OP_CLEAR: begin
        mask  = gated_src;
        value = '0;
      end
      default: begin
        op_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/csr_rmw_guard.sv
module csr_rmw_guard
  import csr_rmw_pkg::*;
(
  input  logic [3:0] addr_hi,
  input  logic [1:0] priv,
  input  logic       mask_any,
  input  logic       op_ok,
  input  logic       hit,
  output logic       fail
);
  localparam logic [1:0] RO_SPACE = 2'b11;

  fault_t flt;
  logic [1:0] min_priv;
  logic [1:0] space;

  always_comb begin
    space          = addr_hi[3:2];
    min_priv       = addr_hi[1:0];
    flt.bad_op     = ~op_ok;
    flt.unimpl     = ~hit;
    flt.priv_low   = (priv < min_priv);
    flt.ro_write   = (space == RO_SPACE) && mask_any;
    fail           = |flt;
  end
endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank
  import csr_rmw_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] ID_VALUE = 32'h5A5A_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_mask,
  input  logic [XLEN-1:0]   wr_val,
  output logic              hit,
  output logic [XLEN-1:0]   rdata
);
  logic [N_RW-1:0]  sel;
  logic [XLEN-1:0]  reg_q   [N_RW];
  logic [XLEN-1:0]  reg_d   [N_RW];
  logic [XLEN-1:0]  sel_dat [N_RW];
  logic             id_sel;

  assign id_sel = (addr == ID_ADDR);

  for (genvar i = 0; i < N_RW; i++) begin : g_rw
    logic upd;
    assign sel[i]     = (addr == RW_ADDR[i]);
    assign upd        = wr_en & sel[i];
    assign sel_dat[i] = sel[i] ? reg_q[i] : '0;

    always_comb begin
      reg_d[i] = (reg_q[i] & ~wr_mask) | (wr_val & wr_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   reg_q[i] <= '0;
      else if (upd) reg_q[i] <= reg_d[i];
    end
  end

  always_comb begin
    hit   = (|sel) | id_sel;
    rdata = id_sel ? ID_VALUE : '0;
    for (int k = 0; k < N_RW; k++) begin
      rdata = rdata | sel_dat[k];
    end
  end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] ID_VALUE = 32'h5A5A_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [11:0]       req_addr,
  input  logic [XLEN-1:0]   req_src,
  input  logic              req_src_nz,
  input  logic [1:0]        req_priv,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [XLEN-1:0]   rsp_old
);
  logic            rst_core_n;
  logic [XLEN-1:0] upd_mask;
  logic [XLEN-1:0] upd_val;
  logic            op_ok;
  logic            mask_any;
  logic            bank_hit;
  logic [XLEN-1:0] bank_rdata;
  logic            access_fail;
  logic            bank_wr_en;

  logic            done_q,  done_d;
  logic            fault_q, fault_d;
  logic [XLEN-1:0] old_q,   old_d;
  logic            old_en;

  csr_rmw_rstsync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  csr_rmw_opdec #(.XLEN(XLEN)) u_dec (
    .op     (req_op),
    .src    (req_src),
    .src_nz (req_src_nz),
    .mask   (upd_mask),
    .value  (upd_val),
    .op_ok  (op_ok)
  );

  assign mask_any = |upd_mask;

  csr_rmw_guard u_guard (
    .addr_hi  (req_addr[11:8]),
    .priv     (req_priv),
    .mask_any (mask_any),
    .op_ok    (op_ok),
    .hit      (bank_hit),
    .fail     (access_fail)
  );

  assign bank_wr_en = req_valid & ~access_fail & mask_any;

  csr_rmw_bank #(.XLEN(XLEN), .ID_VALUE(ID_VALUE)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .addr    (req_addr),
    .wr_en   (bank_wr_en),
    .wr_mask (upd_mask),
    .wr_val  (upd_val),
    .hit     (bank_hit),
    .rdata   (bank_rdata)
  );

  always_comb begin
    done_d  = req_valid;
    fault_d = req_valid & access_fail;
    old_en  = req_valid;
    old_d   = access_fail ? '0 : bank_rdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  old_q <= '0;
    else if (old_en)  old_q <= old_d;
  end

  assign rsp_done  = done_q;
  assign rsp_fault = fault_q;
  assign rsp_old   = old_q;
endmodule

// File: rtl/csr_rmw_chk.sv
module csr_rmw_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic [3:0]      addr_hi,
  input logic            req_src_nz,
  input logic [1:0]      req_priv,
  input logic            bank_hit,
  input logic            bank_wr_en,
  input logic            rsp_done,
  input logic            rsp_fault,
  input logic [XLEN-1:0] rsp_old
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done); // R9
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done); // R9
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_done); // R9
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_old == '0)); // R6
  AST_UNIMPL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bank_hit) |=> rsp_fault); // R6
  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_priv < addr_hi[1:0])) |=> rsp_fault); // R7
  AST_RO_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01 && addr_hi[3:2] == 2'b11) |=> rsp_fault); // R8
  AST_BAD_OP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00) |=> rsp_fault); // R10
  AST_ZERO_SRC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op != 2'b01 && !req_src_nz) |-> !bank_wr_en); // R5
endmodule

bind csr_rmw_unit csr_rmw_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .addr_hi    (req_addr[11:8]),
  .req_src_nz (req_src_nz),
  .req_priv   (req_priv),
  .bank_hit   (bank_hit),
  .bank_wr_en (bank_wr_en),
  .rsp_done   (rsp_done),
  .rsp_fault  (rsp_fault),
  .rsp_old    (rsp_old)
);

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;
  localparam int unsigned XLEN = 32;
  localparam logic [XLEN-1:0] IDV = 32'h5A5A_0001;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic [1:0]      req_op;
  logic [11:0]     req_addr;
  logic [XLEN-1:0] req_src;
  logic            req_src_nz;
  logic [1:0]      req_priv;
  logic            rsp_done;
  logic            rsp_fault;
  logic [XLEN-1:0] rsp_old;

  int total = 0;
  int bad = 0;

  logic [XLEN-1:0] mdl [3];
  logic            p_done;
  logic            p_fault;
  logic [XLEN-1:0] p_old;
  string           p_tag;

  always #10 clk = ~clk;

  csr_rmw_unit #(.XLEN(XLEN), .ID_VALUE(IDV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_src(req_src), .req_src_nz(req_src_nz),
    .req_priv(req_priv), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_old(rsp_old)
  );

  function automatic int idx_of(input logic [11:0] a);
    case (a)
      12'h340: return 0;
      12'h140: return 1;
      12'h041: return 2;
      12'hF11: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: check the response to the previous request, then drive the next.
  task automatic step(input logic v, input logic [1:0] op, input logic [11:0] a,
                      input logic [XLEN-1:0] s, input logic nz, input logic [1:0] pv,
                      input string tag);
    int i;
    logic [XLEN-1:0] m, val, old;
    logic f;
    @(negedge clk);
    chk(p_tag, "done", {31'd0, rsp_done}, {31'd0, p_done});
    if (p_done) begin
      chk(p_tag, "fault", {31'd0, rsp_fault}, {31'd0, p_fault});
      chk(p_tag, "old", rsp_old, p_old);
    end
    i = idx_of(a);
    m = '0; val = '0;
    case (op)
      2'b01: begin m = '1; val = s; end
      2'b10: begin m = nz ? s : '0; val = '1; end
      2'b11: begin m = nz ? s : '0; val = '0; end
      default: ;
    endcase
    f = (op == 2'b00) || (i < 0) || (pv < a[9:8]) || (a[11:10] == 2'b11 && m != '0);
    old = (i == 3) ? IDV : ((i >= 0) ? mdl[i] : '0);
    p_done  = v;
    p_fault = v & f;
    p_old   = f ? '0 : old;
    p_tag   = v ? tag : "R9";
    if (v && !f && i >= 0 && i < 3) mdl[i] = (old & ~m) | (val & m);
    req_valid = v; req_op = op; req_addr = a; req_src = s;
    req_src_nz = nz; req_priv = pv;
  endtask

  task automatic idle();
    step(1'b0, 2'b00, 12'h000, '0, 1'b0, 2'd0, "R9");
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] pool [6];
    pool = '{12'h340, 12'h140, 12'h041, 12'hF11, 12'h341, 12'h7C0};
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) mdl[k] = '0;
    p_done = 1'b0; p_fault = 1'b0; p_old = '0; p_tag = "R1";
    req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_src = '0;
    req_src_nz = 1'b0; req_priv = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "done after reset", {31'd0, rsp_done}, 32'd0);

    // R1 and R5: reads through set with a zero source field
    step(1'b1, 2'b10, 12'h340, '1, 1'b0, 2'd3, "R1");
    step(1'b1, 2'b11, 12'h140, '1, 1'b0, 2'd3, "R1");
    step(1'b1, 2'b10, 12'h041, '1, 1'b0, 2'd3, "R1");
    idle();

    // back-to-back on one register: R2, R3, R4
    step(1'b1, 2'b01, 12'h340, 32'hA5A5_A5A5, 1'b1, 2'd3, "R2");
    step(1'b1, 2'b10, 12'h340, 32'h0F0F_0000, 1'b1, 2'd3, "R3");
    step(1'b1, 2'b11, 12'h340, 32'hF000_00F0, 1'b1, 2'd3, "R4");
    step(1'b1, 2'b01, 12'h340, 32'h1234_5678, 1'b1, 2'd3, "R2");
    step(1'b1, 2'b10, 12'h340, '0, 1'b0, 2'd3, "R2");
    idle();

    // R5: nonzero source but zero field, then read back
    step(1'b1, 2'b01, 12'h140, 32'h00FF_00FF, 1'b1, 2'd1, "R2");
    step(1'b1, 2'b10, 12'h140, 32'hFFFF_FFFF, 1'b0, 2'd1, "R5");
    step(1'b1, 2'b11, 12'h140, 32'hFFFF_FFFF, 1'b0, 2'd1, "R5");
    step(1'b1, 2'b10, 12'h140, '0, 1'b0, 2'd1, "R5");

    // R6: unimplemented, then confirm no change
    step(1'b1, 2'b01, 12'h341, 32'hDEAD_BEEF, 1'b1, 2'd3, "R6");
    step(1'b1, 2'b10, 12'h340, '0, 1'b0, 2'd3, "R6");

    // R7: privilege checks
    step(1'b1, 2'b01, 12'h140, 32'h1111_1111, 1'b1, 2'd0, "R7");
    step(1'b1, 2'b01, 12'h340, 32'h2222_2222, 1'b1, 2'd1, "R7");
    step(1'b1, 2'b10, 12'h140, '0, 1'b0, 2'd1, "R7");
    step(1'b1, 2'b01, 12'h041, 32'h3333_3333, 1'b1, 2'd0, "R7");
    step(1'b1, 2'b10, 12'h041, '0, 1'b0, 2'd0, "R7");

    // R8 and R11: read-only space
    step(1'b1, 2'b10, 12'hF11, '1, 1'b0, 2'd3, "R11");
    step(1'b1, 2'b01, 12'hF11, 32'h0, 1'b1, 2'd3, "R8");
    step(1'b1, 2'b10, 12'hF11, '0, 1'b1, 2'd3, "R8");
    step(1'b1, 2'b11, 12'hF11, 32'h1, 1'b1, 2'd3, "R8");
    step(1'b1, 2'b11, 12'hF11, '0, 1'b0, 2'd3, "R11");

    // R10: unused operation code
    step(1'b1, 2'b00, 12'h340, 32'hFFFF_FFFF, 1'b1, 2'd3, "R10");
    step(1'b1, 2'b10, 12'h340, '0, 1'b0, 2'd3, "R10");
    idle();

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic v;
      logic [1:0] op;
      logic [11:0] a;
      logic [XLEN-1:0] s;
      string t;
      v  = ($urandom % 5) != 0;
      op = 2'($urandom);
      a  = pool[$urandom % 6];
      s  = (($urandom % 6) == 0) ? '0 : $urandom;
      case (op)
        2'b01: t = "R2";
        2'b10: t = "R3";
        2'b11: t = "R4";
        default: t = "R10";
      endcase
      step(v, op, a, s, 1'(($urandom % 4) != 0), 2'($urandom), t);
    end
    idle();
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule